// File: doc/BRIEF.md
# Narrow-Bus Sizing Cycle Controller

This controller terminates every processor bus cycle that does not go to main memory. The processor presents an address, a direction, a size code and write data, then waits until it sees one of two terminations: a transfer acknowledge or a transfer error. The controller returns a one-cycle address acknowledge as soon as it accepts the request. It then decodes the address into one of three kinds of target. The first is a region of 8-bit peripherals. The second is a region of 32-bit devices, each with its own select line. Any other address is unmapped.

The processor has no dynamic bus sizing, so an 8-bit peripheral tied directly to its data bus would appear only once every four bytes. This block fixes that. For the 8-bit region it splits one request into one, two or four byte strobes on a separate 8-bit bus. Each strobe waits for that bus's ready input. Write bytes are picked from the lane that matches each byte offset. Read bytes are gathered into a holding register, and the requester receives a single acknowledge after the last byte. A wait counter ends any cycle that stalls too long with a transfer error. Devices flagged as having their own error logic are exempt from this timeout and may stretch a cycle for as long as they need.

Top module: `pbus_sizer_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all three terminations (`cpu_aack_n`, `cpu_tack_n`, `cpu_tea_n`) are high, `nb_cs_n` is high and `dev_sel` is all zero.
- R2: An accepted `cpu_start` drives `cpu_aack_n` low for exactly one cycle: the cycle right after the edge that sampled the start. Acknowledge is never low at any other time.
- R3: Byte strobes on the 8-bit bus go through the offsets of a request in ascending order. Each strobe holds `nb_cs_n` low until `nb_rdy_n` is sampled low, then releases it for at least one cycle. `nb_addr[1:0]` carries the offset, and the upper bits of `nb_addr` come from `cpu_addr`.
- R4: A byte written at offset k (k = 0..3) takes `cpu_wdata[31-8k -: 8]`, so offset 0 is the most significant lane.
- R5: A read places the byte fetched at offset k in `cpu_rdata[31-8k -: 8]`, returns zero in the lanes it did not fetch, and gives one `cpu_tack_n` pulse after the final byte.
- R6: Size code 2'b00 is one byte at offset `addr[1:0]`. 2'b01 is two bytes starting at offset `{addr[1],0}`, ignoring `addr[0]`. 2'b10 and 2'b11 are four bytes starting at offset 0, ignoring `addr[1:0]`.
- R7: Addresses with `addr[31:28]` = 4'hE select the 8-bit region. Addresses with `addr[31:28]` = 4'hC and device index `addr[25:24]` below N_DEV select a 32-bit device. For such a cycle, `dev_sel` is one-hot on that index. `cpu_rdata` returns `dev_rdata` with the acknowledge, which is given once `dev_rdy_n` is sampled low.
- R8: A cycle ends with a single `cpu_tea_n` pulse and no `cpu_tack_n` when TIMEOUT consecutive waiting cycles pass without a ready. The count restarts for every byte, so each strobe whose ready arrives within TIMEOUT cycles completes.
- R9: A timeout during a split access abandons the bytes not yet transferred. No further strobe is issued for that request.
- R10: Devices marked in OWN_ERR_MASK (by default device 3) never time out. For any 32-bit device, `dev_err_n` sampled low ends the cycle with `cpu_tea_n`.
- R11: An unmapped address drives no strobe and no select, and ends with `cpu_tea_n` after TIMEOUT waiting cycles.
- R12: `cpu_tack_n` and `cpu_tea_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_start | input | 1 | Request valid for one cycle, sampled while idle |
| cpu_addr | input | 32 | Request byte address, held until termination |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Size code, see R6 |
| cpu_wdata | input | 32 | Write data, offset 0 in bits 31:24 |
| cpu_rdata | output | 32 | Read data, valid with the acknowledge |
| cpu_aack_n | output | 1 | Address acknowledge, active low |
| cpu_tack_n | output | 1 | Transfer acknowledge, active low |
| cpu_tea_n | output | 1 | Transfer error, active low |
| nb_addr | output | NB_ADDR_W | 8-bit bus byte address |
| nb_wdata | output | 8 | 8-bit bus write byte |
| nb_rdata | input | 8 | 8-bit bus read byte |
| nb_cs_n | output | 1 | 8-bit bus strobe, active low |
| nb_wr | output | 1 | 8-bit bus direction, 1 = write |
| nb_rdy_n | input | 1 | 8-bit bus ready, active low |
| dev_sel | output | N_DEV | 32-bit device selects, active high |
| dev_rdy_n | input | 1 | 32-bit device ready, active low |
| dev_err_n | input | 1 | 32-bit device error, active low |
| dev_rdata | input | 32 | 32-bit device read data |

## Verification
A corrupted byte offset or remaining-byte count shows at the ports within a single strobe. The wrong `nb_addr[1:0]` appears, a byte lands in the wrong lane of `cpu_rdata`, or the acknowledge arrives after the wrong number of strobes. A wait counter that fails to restart, or that uses the wrong limit, moves the `cpu_tea_n` pulse away from the exact edge predicted from TIMEOUT. The boundary pair of a ready after TIMEOUT-1 and after TIMEOUT waits exposes an off-by-one within about 20 cycles. A region or exemption decode error shows as a select on the wrong line, a strobe on an unmapped access, or a timeout where a device should have been allowed to stall.

// File: rtl/pbus_pkg.sv
// Package: shared state and region types plus the size-code helpers.
// Assumes a 32-bit processor bus whose byte offset 0 lies in bits 31:24.
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NBYTE,
        ST_NGAP,
        ST_WIDE,
        ST_MISS
    } pbus_state_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_NARROW,
        RG_WIDE
    } pbus_region_t;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    // First byte offset of a request, from its size code and low address bits.
    function automatic logic [1:0] first_offset(input logic [1:0] size, input logic [1:0] lo);
        case (size)
            SZ_BYTE: first_offset = lo;
            SZ_HALF: first_offset = {lo[1], 1'b0};
            default: first_offset = 2'b00;
        endcase
    endfunction

    // Number of byte strobes that a request needs.
    function automatic logic [2:0] byte_count(input logic [1:0] size);
        case (size)
            SZ_BYTE: byte_count = 3'd1;
            SZ_HALF: byte_count = 3'd2;
            default: byte_count = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pbus_decode.sv
// Address decoder: classifies a request address as 8-bit region, 32-bit
// device or unmapped, and extracts the device index.
// Assumes the region tag sits in address bits 31:28.
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int          N_DEV      = 4,
    parameter int          DEV_LSB    = 24,
    parameter logic [3:0]  NARROW_TAG = 4'hE,
    parameter logic [3:0]  WIDE_TAG   = 4'hC,
    localparam int         IDX_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic [31:0]      addr,
    output pbus_region_t     region,
    output logic [IDX_W-1:0] dev_idx
);

    localparam logic [IDX_W:0] DEV_LIMIT = (IDX_W+1)'(N_DEV);

    assign dev_idx = addr[DEV_LSB +: IDX_W];

    // Region classification from the tag and the device index range.
    always_comb begin
        if (addr[31:28] == NARROW_TAG)
            region = RG_NARROW;
        else if (addr[31:28] == WIDE_TAG && {1'b0, dev_idx} < DEV_LIMIT)
            region = RG_WIDE;
        else
            region = RG_NONE;
    end

endmodule

// File: rtl/pbus_wait_timer.sv
// Wait-state timer: counts consecutive waiting cycles and flags expiry in the
// cycle where the LIMIT-th wait would be spent without a ready.
// Assumes clr has priority and that LIMIT is at least 2.
module pbus_wait_timer #(
    parameter int  LIMIT = 256,
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt;

    // Count waiting cycles, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pbus_lane_steer.sv
// Lane steering: picks the write byte for a byte offset and merges a read
// byte into its lane of the holding word. Offset 0 maps to bits 31:24.
module pbus_lane_steer (
    input  logic [1:0]  offset,
    input  logic [31:0] wdata,
    input  logic [31:0] hold,
    input  logic [7:0]  rbyte,
    output logic [7:0]  wbyte,
    output logic [31:0] merged
);

    // Select the outgoing write byte.
    always_comb begin
        case (offset)
            2'd0:    wbyte = wdata[31:24];
            2'd1:    wbyte = wdata[23:16];
            2'd2:    wbyte = wdata[15:8];
            default: wbyte = wdata[7:0];
        endcase
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign merged[31-8*g -: 8] = (offset == 2'(g)) ? rbyte : hold[31-8*g -: 8];
    end

endmodule

// File: rtl/pbus_sizer_ctrl.sv
// Peripheral cycle controller: accepts one processor request at a time,
// returns address acknowledge, splits 8-bit-region requests into byte
// strobes, drives 32-bit device selects, and ends every cycle with a
// transfer acknowledge or a transfer error (timeout, device error, unmapped).
// Assumes the processor holds address, size and data until termination.
module pbus_sizer_ctrl
    import pbus_pkg::*;
#(
    parameter int               NB_ADDR_W    = 16,
    parameter int               N_DEV        = 4,
    parameter int               TIMEOUT      = 256,
    parameter int               DEV_LSB      = 24,
    parameter logic [3:0]       NARROW_TAG   = 4'hE,
    parameter logic [3:0]       WIDE_TAG     = 4'hC,
    parameter logic [N_DEV-1:0] OWN_ERR_MASK = N_DEV'(1) << (N_DEV - 1),
    localparam int              IDX_W        = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_start,
    input  logic [31:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic [1:0]           cpu_size,
    input  logic [31:0]          cpu_wdata,
    output logic [31:0]          cpu_rdata,
    output logic                 cpu_aack_n,
    output logic                 cpu_tack_n,
    output logic                 cpu_tea_n,
    output logic [NB_ADDR_W-1:0] nb_addr,
    output logic [7:0]           nb_wdata,
    input  logic [7:0]           nb_rdata,
    output logic                 nb_cs_n,
    output logic                 nb_wr,
    input  logic                 nb_rdy_n,
    output logic [N_DEV-1:0]     dev_sel,
    input  logic                 dev_rdy_n,
    input  logic                 dev_err_n,
    input  logic [31:0]          dev_rdata
);

    pbus_state_t          state;
    pbus_region_t         dec_region;
    logic [IDX_W-1:0]     dec_idx;
    logic [IDX_W-1:0]     req_dev;
    logic                 req_wr;
    logic                 req_exempt;
    logic [NB_ADDR_W-3:0] req_page;
    logic [1:0]           req_off;
    logic [2:0]           req_left;
    logic [31:0]          req_wdata;
    logic [31:0]          hold;
    logic [31:0]          merged;
    logic                 aack_q, tack_q, tea_q;
    logic                 waiting, ready, run, expired;

    pbus_decode #(
        .N_DEV(N_DEV), .DEV_LSB(DEV_LSB),
        .NARROW_TAG(NARROW_TAG), .WIDE_TAG(WIDE_TAG)
    ) u_decode (
        .addr(cpu_addr), .region(dec_region), .dev_idx(dec_idx)
    );

    pbus_lane_steer u_steer (
        .offset(req_off), .wdata(req_wdata), .hold(hold),
        .rbyte(nb_rdata), .wbyte(nb_wdata), .merged(merged)
    );

    // Timer inputs: run while a target is awaited, clear whenever not waiting or on a ready.
    assign waiting = (state == ST_NBYTE) || (state == ST_WIDE) || (state == ST_MISS);
    assign ready   = ((state == ST_NBYTE) && !nb_rdy_n) || ((state == ST_WIDE) && !dev_rdy_n);
    assign run     = waiting && !ready && !((state == ST_WIDE) && req_exempt);

    pbus_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(!waiting || ready), .run(run), .expired(expired)
    );

    // Request sequencing, byte stepping, read assembly and termination pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            req_dev    <= '0;
            req_wr     <= 1'b0;
            req_exempt <= 1'b0;
            req_page   <= '0;
            req_off    <= '0;
            req_left   <= '0;
            req_wdata  <= '0;
            hold       <= '0;
            aack_q     <= 1'b1;
            tack_q     <= 1'b1;
            tea_q      <= 1'b1;
        end else begin
            aack_q <= 1'b1;
            tack_q <= 1'b1;
            tea_q  <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (cpu_start) begin
                        aack_q     <= 1'b0;
                        req_wr     <= cpu_wr;
                        req_wdata  <= cpu_wdata;
                        req_page   <= cpu_addr[NB_ADDR_W-1:2];
                        req_off    <= first_offset(cpu_size, cpu_addr[1:0]);
                        req_left   <= byte_count(cpu_size);
                        req_dev    <= dec_idx;
                        req_exempt <= OWN_ERR_MASK[dec_idx];
                        hold       <= '0;
                        case (dec_region)
                            RG_NARROW: state <= ST_NBYTE;
                            RG_WIDE:   state <= ST_WIDE;
                            default:   state <= ST_MISS;
                        endcase
                    end
                end
                ST_NBYTE: begin
                    if (!nb_rdy_n) begin
                        if (!req_wr)
                            hold <= merged;
                        if (req_left == 3'd1) begin
                            tack_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            req_left <= req_left - 3'd1;
                            req_off  <= req_off + 2'd1;
                            state    <= ST_NGAP;
                        end
                    end else if (expired) begin
                        tea_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                ST_NGAP: state <= ST_NBYTE;
                ST_WIDE: begin
                    if (!dev_rdy_n) begin
                        if (!req_wr)
                            hold <= dev_rdata;
                        tack_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else if (!dev_err_n || expired) begin
                        tea_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                ST_MISS: begin
                    if (expired) begin
                        tea_q <= 1'b0;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < N_DEV; i++) begin : g_sel
        assign dev_sel[i] = (state == ST_WIDE) && (req_dev == IDX_W'(i));
    end

    assign nb_cs_n    = (state != ST_NBYTE);
    assign nb_wr      = req_wr;
    assign nb_addr    = {req_page, req_off};
    assign cpu_rdata  = hold;
    assign cpu_aack_n = aack_q;
    assign cpu_tack_n = tack_q;
    assign cpu_tea_n  = tea_q;

endmodule

// File: rtl/pbus_sizer_chk.sv
// Checker for pbus_sizer_ctrl: port-level protocol properties, bound to
// every instance of the controller.
module pbus_sizer_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_start,
    input logic             cpu_aack_n,
    input logic             cpu_tack_n,
    input logic             cpu_tea_n,
    input logic             nb_cs_n,
    input logic             nb_rdy_n,
    input logic [N_DEV-1:0] dev_sel
);

    a_r2_aack_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_aack_n |=> cpu_aack_n);

    a_r2_aack_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_aack_n |-> $past(cpu_start));

    a_r12_single_end: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cpu_tack_n && !cpu_tea_n));

    a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !nb_cs_n |-> (dev_sel == '0));

    a_r3_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!nb_cs_n && !nb_rdy_n) |=> nb_cs_n);

    a_r9_error_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_tea_n |-> (nb_cs_n && dev_sel == '0));

endmodule

bind pbus_sizer_ctrl pbus_sizer_chk #(.N_DEV(N_DEV)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start),
    .cpu_aack_n(cpu_aack_n), .cpu_tack_n(cpu_tack_n), .cpu_tea_n(cpu_tea_n),
    .nb_cs_n(nb_cs_n), .nb_rdy_n(nb_rdy_n), .dev_sel(dev_sel)
);

// File: tb/pbus_sizer_ctrl_bench.sv
module pbus_sizer_ctrl_bench;

    localparam int TMO = 16;
    localparam int VW  = 99;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_start = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_aack_n, cpu_tack_n, cpu_tea_n;
    logic [15:0] nb_addr;
    logic [7:0]  nb_wdata, nb_rdata;
    logic        nb_cs_n, nb_wr, nb_rdy_n;
    logic [3:0]  dev_sel;
    logic        dev_rdy_n, dev_err_n;
    logic [31:0] dev_rdata;

    int checks = 0;
    int failures = 0;

    // Peripheral model controls (driven from the initial block only)
    int nb_wait = 0;
    int nb_ok_bytes = 1000;
    int nb_base = 0;
    int dev_wait = 0;
    int dev_err_at = 1000;
    logic dev_rdy_en = 1'b1;

    // Model state (driven by the model process only)
    logic [7:0] mem [16];
    logic [1:0] log_off [16];
    int cs_cnt = 0, dev_cnt = 0, ack_total = 0, cs_total = 0, sel_total = 0;
    logic [3:0] sel_last = '0;

    always #2 clk = ~clk;

    pbus_sizer_ctrl #(.TIMEOUT(TMO)) u_pbus_sizer_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_start(cpu_start), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_aack_n(cpu_aack_n), .cpu_tack_n(cpu_tack_n),
        .cpu_tea_n(cpu_tea_n), .nb_addr(nb_addr), .nb_wdata(nb_wdata),
        .nb_rdata(nb_rdata), .nb_cs_n(nb_cs_n), .nb_wr(nb_wr), .nb_rdy_n(nb_rdy_n),
        .dev_sel(dev_sel), .dev_rdy_n(dev_rdy_n), .dev_err_n(dev_err_n),
        .dev_rdata(dev_rdata)
    );

    assign nb_rdy_n  = !(!nb_cs_n && cs_cnt == nb_wait && (ack_total - nb_base) < nb_ok_bytes);
    assign nb_rdata  = mem[nb_addr[3:0]];
    assign dev_rdy_n = !((dev_sel != '0) && dev_rdy_en && dev_cnt == dev_wait);
    assign dev_err_n = !((dev_sel != '0) && dev_cnt == dev_err_at);
    assign dev_rdata = 32'hC0DE_0000 | {28'h0, dev_sel};

    // 8-bit peripheral and 32-bit device behaviour
    always @(posedge clk) begin
        if (!nb_cs_n) begin
            cs_cnt   <= cs_cnt + 1;
            cs_total <= cs_total + 1;
        end else begin
            cs_cnt <= 0;
        end
        if (!nb_cs_n && !nb_rdy_n) begin
            log_off[ack_total % 16] <= nb_addr[1:0];
            ack_total <= ack_total + 1;
            if (nb_wr) mem[nb_addr[3:0]] <= nb_wdata;
        end
        if (dev_sel != '0) begin
            dev_cnt   <= dev_cnt + 1;
            sel_total <= sel_total + 1;
            sel_last  <= dev_sel;
        end else begin
            dev_cnt <= 0;
        end
    end

    // Stimulus table: {wr, size, addr, wdata, expected read data}
    localparam logic [VW-1:0] VEC [11] = '{
        {1'b1, 2'b10, 32'hE000_0000, 32'h1122_3344, 32'h0000_0000},
        {1'b0, 2'b10, 32'hE000_0000, 32'h0000_0000, 32'h1122_3344},
        {1'b0, 2'b00, 32'hE000_0002, 32'h0000_0000, 32'h0000_3300},
        {1'b0, 2'b01, 32'hE000_0002, 32'h0000_0000, 32'h0000_3344},
        {1'b1, 2'b00, 32'hE000_0001, 32'hAABB_CCDD, 32'h0000_0000},
        {1'b0, 2'b10, 32'hE000_0000, 32'h0000_0000, 32'h11BB_3344},
        {1'b1, 2'b01, 32'hE000_0006, 32'h0000_EEFF, 32'h0000_0000},
        {1'b0, 2'b10, 32'hE000_0004, 32'h0000_0000, 32'h0000_EEFF},
        {1'b0, 2'b01, 32'hE000_0003, 32'h0000_0000, 32'h0000_3344},
        {1'b0, 2'b11, 32'hE000_0001, 32'h0000_0000, 32'h11BB_3344},
        {1'b0, 2'b00, 32'hE000_0007, 32'h0000_0000, 32'h0000_00FF}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [1:0] size);
        return (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [1:0] exp_first(input logic [1:0] size, input logic [31:0] a);
        return (size == 2'b00) ? a[1:0] : (size == 2'b01) ? {a[1], 1'b0} : 2'b00;
    endfunction

    // One processor request; returns data, termination kind and negedge count to termination.
    task automatic xfer(input logic wr, input logic [1:0] size, input logic [31:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rdata,
                        output bit got_tack, output bit got_tea, output int ncyc);
        bit aack_hi;
        @(negedge clk);
        nb_base   = ack_total;
        cpu_start = 1'b1;
        cpu_wr    = wr;
        cpu_size  = size;
        cpu_addr  = addr;
        cpu_wdata = wdata;
        @(negedge clk);
        cpu_start = 1'b0;
        check(cpu_aack_n == 1'b0, "R2 aack low after start", {31'b0, cpu_aack_n}, 32'h0);
        ncyc = 1;
        aack_hi = 1'b1;
        while (cpu_tack_n && cpu_tea_n && ncyc < 3000) begin
            @(negedge clk);
            ncyc++;
            if (ncyc == 2) aack_hi = cpu_aack_n;
        end
        check(aack_hi, "R2 aack single cycle", {31'b0, aack_hi}, 32'h1);
        rdata    = cpu_rdata;
        got_tack = !cpu_tack_n;
        got_tea  = !cpu_tea_n;
    endtask

    initial begin : main
        logic [31:0] rd;
        bit tk, te;
        int n, cs0, sel0;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        check(cpu_aack_n && cpu_tack_n && cpu_tea_n, "R1 terminations idle in reset",
              {29'b0, cpu_aack_n, cpu_tack_n, cpu_tea_n}, 32'h7);
        check(nb_cs_n && dev_sel == '0, "R1 no strobe or select in reset",
              {27'b0, nb_cs_n, dev_sel}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_aack_n && cpu_tack_n && cpu_tea_n && nb_cs_n && dev_sel == '0,
              "R1 idle after reset", {28'b0, dev_sel}, 32'h0);

        // Table walk: R3 R4 R5 R6 data, strobe count and offset order
        for (int v = 0; v < 11; v++) begin
            logic [VW-1:0] e;
            int cnt;
            logic [1:0] f;
            e = VEC[v];
            nb_wait = v % 3;
            xfer(e[98], e[97:96], e[95:64], e[63:32], rd, tk, te, n);
            cnt = exp_count(e[97:96]);
            f   = exp_first(e[97:96], e[95:64]);
            check(tk && !te, "R5 single acknowledge", {30'b0, tk, te}, 32'h2);
            check(ack_total - nb_base == cnt, "R6 strobe count", ack_total - nb_base, cnt);
            for (int k = 0; k < cnt; k++)
                check(log_off[(nb_base + k) % 16] == f + 2'(k), "R3 ascending offsets",
                      {30'b0, log_off[(nb_base + k) % 16]}, {30'b0, f + 2'(k)});
            if (!e[98])
                check(rd == e[31:0], "R4 R5 lane data", rd, e[31:0]);
        end

        // R8 boundary: ready after TMO-1 waits completes, after TMO waits errors
        nb_wait = TMO - 1;
        xfer(1'b0, 2'b10, 32'hE000_0000, 32'h0, rd, tk, te, n);
        check(tk && !te && rd == 32'h11BB_3344, "R8 per-byte restart completes", rd, 32'h11BB_3344);
        nb_wait = TMO;
        xfer(1'b0, 2'b00, 32'hE000_0000, 32'h0, rd, tk, te, n);
        check(te && !tk, "R8 timeout error", {30'b0, tk, te}, 32'h1);
        check(n == TMO + 1, "R8 timeout timing", n, TMO + 1);

        // R9 abort after two bytes of a word
        nb_wait = 0;
        nb_ok_bytes = 2;
        xfer(1'b0, 2'b10, 32'hE000_0000, 32'h0, rd, tk, te, n);
        cs0 = cs_total;
        repeat (6) @(negedge clk);
        check(te && !tk, "R9 split timeout error", {30'b0, tk, te}, 32'h1);
        check(ack_total - nb_base == 2, "R9 bytes before abort", ack_total - nb_base, 2);
        check(cs_total == cs0 && nb_cs_n, "R9 no strobe after abort", cs_total - cs0, 0);
        nb_ok_bytes = 1000;

        // R7 32-bit device read
        dev_wait = 3;
        xfer(1'b0, 2'b10, 32'hC200_0000, 32'h0, rd, tk, te, n);
        check(tk && rd == 32'hC0DE_0004, "R7 device read data", rd, 32'hC0DE_0004);
        check(sel_last == 4'b0100, "R7 select index", {28'b0, sel_last}, 32'h4);
        check(n == dev_wait + 2, "R7 ack timing", n, dev_wait + 2);

        // R10 non-exempt device times out, exempt device stalls until its own error
        dev_rdy_en = 1'b0;
        dev_err_at = 60;
        xfer(1'b0, 2'b10, 32'hC100_0000, 32'h0, rd, tk, te, n);
        check(te && n == TMO + 1, "R10 non-exempt device timeout", n, TMO + 1);
        xfer(1'b0, 2'b10, 32'hC300_0000, 32'h0, rd, tk, te, n);
        check(te && !tk && n == 62, "R10 exempt device own error", n, 62);
        dev_rdy_en = 1'b1;
        dev_err_at = 1000;

        // R11 unmapped address
        cs0 = cs_total;
        sel0 = sel_total;
        xfer(1'b0, 2'b10, 32'h1000_0000, 32'h0, rd, tk, te, n);
        check(te && !tk && n == TMO + 1, "R11 unmapped timeout", n, TMO + 1);
        check(cs_total == cs0 && sel_total == sel0, "R11 no strobe or select",
              (cs_total - cs0) + (sel_total - sel0), 0);

        // R12: terminations mutually exclusive on a normal narrow write afterwards
        xfer(1'b1, 2'b00, 32'hE000_0005, 32'h0077_0000, rd, tk, te, n);
        check(tk != te, "R12 one termination", {30'b0, tk, te}, 32'h2);
        xfer(1'b0, 2'b10, 32'hE000_0004, 32'h0, rd, tk, te, n);
        check(rd == 32'h0077_EEFF, "R4 byte write lane", rd, 32'h0077_EEFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule